// File: doc/BRIEF.md
# Time-Slot Serial Audio Transmitter

This block sends audio sample words on a single serial data line in time-slot (network) mode. Sample words are written into a small internal holding queue, left-aligned in a 32-bit input. The block acts as clock and frame master. A single-cycle bit-tick input paces it, and each tick toggles the generated bit clock once, so one serial bit takes two ticks.

Static configuration inputs set the frame. They select the word length (which is also the slot width), the number of slots in a frame, MSB-first or LSB-first order, and which bit-clock edge launches data. They also select the frame-sync polarity, a one-bit or word-long frame sync, and an early frame sync. An early sync leads the first data bit of the frame by one bit period. A per-slot mask marks slots that carry no queue data. An empty queue at the start of an unmasked slot raises a sticky underrun flag. The configuration is expected to stay constant while the transmitter is running.

Top module: `tdm_audio_tx`

## Requirements
- R1: The word length is 2*(wordCode+1) bits, and every code of 11 (0xb) or above gives 24 bits. Only the top word-length bits of the 32-bit queue entry are transmitted.
- R2: A frame holds slotsM1+1 slots of word-length bits each, and frames follow one another with no gap.
- R3: With lsbFirst=0 a word goes out starting at bit 31 and moving down. With lsbFirst=1 it starts at bit 32-wordlength and moves up.
- R4: While the transmitter runs, sclk toggles once per bitTick. sdOut and fsOut change only when sclk leaves its idle level, which is 1 when fallLaunch=1 (data launched on falling edges) and 0 otherwise.
- R5: fsOut is active high when fsInvert=0 and active low when fsInvert=1.
- R6: With fsOneBit=0 the frame sync covers all of slot 0. With fsOneBit=1 it covers only the first bit of the frame.
- R7: With fsEarly=1 the frame sync starts one bit before the frame's first data bit. After enabling, one lead-in bit with data 0 and an active frame sync comes before the first frame.
- R8: The transmitter runs only when enable and txEnable are both 1. Otherwise, one clock later, sdOut=0, fsOut is at its inactive level and sclk is at its idle level.
- R9: A slot whose slotMask bit is 1 sends all zeros and takes no word from the queue.
- R10: An empty queue at the first bit of an unmasked slot makes that slot all zeros and sets underrun. underrun stays set until a clrUnderrun pulse when no new underrun occurs at the same time.
- R11: The queue holds DEPTH words in write order. wrReady is 0 exactly when the queue is full, and a word is accepted when wrValid and wrReady are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | Half-bit pacing pulse |
| enable | input | 1 | Global enable |
| txEnable | input | 1 | Transmit enable |
| wordCode | input | 4 | Word length code |
| slotsM1 | input | SLOT_W | Slots per frame minus one |
| lsbFirst | input | 1 | 1: send least significant bit first |
| fallLaunch | input | 1 | 1: data changes on falling sclk edge |
| fsInvert | input | 1 | 1: frame sync active low |
| fsOneBit | input | 1 | 1: one-bit frame sync, 0: word-long |
| fsEarly | input | 1 | 1: frame sync one bit early |
| slotMask | input | MAX_SLOTS | Per-slot mask, 1 = slot sends zeros |
| wrValid | input | 1 | Queue write request |
| wrData | input | 32 | Left-aligned sample word |
| wrReady | output | 1 | Queue not full |
| clrUnderrun | input | 1 | Clears the underrun flag |
| sclk | output | 1 | Generated bit clock |
| fsOut | output | 1 | Generated frame sync |
| sdOut | output | 1 | Serial data |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench sweeps every combination of the five mode bits (shift order, launch edge, sync polarity, sync length, early sync) across 4-bit and 8-bit words and across one-slot and three-slot frames. Some of the three-slot runs mask the middle slot or the last slot. Separate runs use 20-bit, 24-bit and clamped-code words. Each frame's serial bits are rebuilt from pseudo-random words whose bits are all distinct. A wrong bit index, slot count or ordering therefore shows up as a data mismatch, and the frame sync is checked against a window computed from the bit position. Every run feeds one word fewer than the frames need, so the last unmasked slot shows the underrun. The bench also checks that the flag does not rise early, that it clears, and that masked slots leave the queue contents for the next slot.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  // Queue entries are left-aligned in this width.
  localparam int WORD_W = 32;

  // Per-bit strobes from the frame sequencer to the datapath.
  typedef struct packed {
    logic       launch;  // a new serial bit is produced this cycle
    logic       lead;    // the bit is the early-sync lead-in bit
    logic       load;    // first bit of a slot
    logic       masked;  // current slot is masked
    logic [4:0] bitIdx;  // bit position inside the slot
  } txStrobe_t;

  function automatic logic [5:0] wordBitsOf(input logic [3:0] code);
    return (code >= 4'hb) ? 6'd24 : ({1'b0, code, 1'b0} + 6'd2);
  endfunction
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int MAX_SLOTS = 32,
  localparam int SLOT_W = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 running,
  input  logic                 bitTick,
  input  logic [5:0]           wordBits,
  input  logic [SLOT_W-1:0]    slotsM1,
  input  logic                 fallLaunch,
  input  logic                 fsInvert,
  input  logic                 fsOneBit,
  input  logic                 fsEarly,
  input  logic [MAX_SLOTS-1:0] slotMask,
  output logic                 sclk,
  output logic                 fsOut,
  output txStrobe_t            st
);
  logic [4:0]        bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              leadPend;
  logic              launch, lead, lastBit, lastSlot, fsActNow;

  // A new bit is launched when sclk leaves its idle level.
  assign launch   = running && bitTick && (sclk == fallLaunch);
  assign lead     = launch && leadPend && fsEarly;
  assign lastBit  = ({1'b0, bitCnt} == (wordBits - 6'd1));
  assign lastSlot = (slotCnt == slotsM1);

  always_comb begin
    if (lead) begin
      fsActNow = 1'b1;
    end else if (fsEarly) begin
      fsActNow = fsOneBit ? (lastBit && lastSlot)
                          : ((lastBit && lastSlot) || (slotCnt == '0 && !lastBit));
    end else begin
      fsActNow = fsOneBit ? (slotCnt == '0 && bitCnt == '0) : (slotCnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk     <= 1'b0;
      fsOut    <= 1'b0;
      bitCnt   <= '0;
      slotCnt  <= '0;
      leadPend <= 1'b1;
    end else if (!running) begin
      sclk     <= fallLaunch;
      fsOut    <= fsInvert;
      bitCnt   <= '0;
      slotCnt  <= '0;
      leadPend <= 1'b1;
    end else begin
      if (bitTick) sclk <= ~sclk;
      if (launch) begin
        fsOut    <= fsActNow ^ fsInvert;
        leadPend <= 1'b0;
        if (!lead) begin
          if (lastBit) begin
            bitCnt  <= '0;
            slotCnt <= lastSlot ? '0 : slotCnt + 1'b1;
          end else begin
            bitCnt <= bitCnt + 5'd1;
          end
        end
      end
    end
  end

  assign st.launch = launch;
  assign st.lead   = lead;
  assign st.load   = launch && !lead && (bitCnt == '0);
  assign st.masked = slotMask[slotCnt];
  assign st.bitIdx = bitCnt;
endmodule

// File: rtl/tdm_tx_dp.sv
module tdm_tx_dp
  import tdm_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              running,
  input  txStrobe_t         st,
  input  logic [5:0]        wordBits,
  input  logic              lsbFirst,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  output logic              wrReady,
  input  logic              clrUnderrun,
  output logic              sdOut,
  output logic              underrun
);
  // DEPTH is a power of two so the pointers wrap on their own.
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [PTR_W:0]    count;
  logic [WORD_W-1:0] wordReg, pick, curWord;
  logic [5:0]        idx;
  logic              empty, push, pop, starve, outBit;

  assign empty   = (count == '0);
  assign wrReady = (count != (PTR_W+1)'(DEPTH));
  assign push    = wrValid && wrReady;
  assign pop     = st.load && !st.masked && !empty;
  assign starve  = st.load && !st.masked && empty;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
    end
  end

  always_comb begin
    pick    = (st.masked || empty) ? '0 : mem[rdPtr];
    curWord = st.load ? pick : wordReg;
    if (lsbFirst) idx = 6'(WORD_W) - wordBits + {1'b0, st.bitIdx};
    else          idx = 6'(WORD_W - 1) - {1'b0, st.bitIdx};
    outBit = curWord[idx[4:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdOut   <= 1'b0;
      wordReg <= '0;
    end else if (!running) begin
      sdOut <= 1'b0;
    end else if (st.launch) begin
      sdOut <= st.lead ? 1'b0 : outBit;
      if (st.load) wordReg <= pick;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            underrun <= 1'b0;
    else if (starve)      underrun <= 1'b1;
    else if (clrUnderrun) underrun <= 1'b0;
  end
endmodule

// File: rtl/tdm_audio_tx.sv
module tdm_audio_tx
  import tdm_tx_pkg::*;
#(
  parameter int MAX_SLOTS = 32,
  parameter int DEPTH = 4,
  localparam int SLOT_W = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 enable,
  input  logic                 txEnable,
  input  logic [3:0]           wordCode,
  input  logic [SLOT_W-1:0]    slotsM1,
  input  logic                 lsbFirst,
  input  logic                 fallLaunch,
  input  logic                 fsInvert,
  input  logic                 fsOneBit,
  input  logic                 fsEarly,
  input  logic [MAX_SLOTS-1:0] slotMask,
  input  logic                 wrValid,
  input  logic [WORD_W-1:0]    wrData,
  output logic                 wrReady,
  input  logic                 clrUnderrun,
  output logic                 sclk,
  output logic                 fsOut,
  output logic                 sdOut,
  output logic                 underrun
);
  txStrobe_t  st;
  logic       running;
  logic [5:0] wordBits;

  assign running  = enable && txEnable;
  assign wordBits = wordBitsOf(wordCode);

  tdm_tx_ctrl #(.MAX_SLOTS(MAX_SLOTS)) ctrl (
    .clk(clk), .rstN(rstN), .running(running), .bitTick(bitTick),
    .wordBits(wordBits), .slotsM1(slotsM1), .fallLaunch(fallLaunch),
    .fsInvert(fsInvert), .fsOneBit(fsOneBit), .fsEarly(fsEarly),
    .slotMask(slotMask), .sclk(sclk), .fsOut(fsOut), .st(st)
  );

  tdm_tx_dp #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .running(running), .st(st),
    .wordBits(wordBits), .lsbFirst(lsbFirst), .wrValid(wrValid),
    .wrData(wrData), .wrReady(wrReady), .clrUnderrun(clrUnderrun),
    .sdOut(sdOut), .underrun(underrun)
  );
endmodule

// File: rtl/tdm_audio_tx_chk.sv
module tdm_audio_tx_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic txEnable,
  input logic bitTick,
  input logic fallLaunch,
  input logic clrUnderrun,
  input logic wrReady,
  input logic sclk,
  input logic sdOut,
  input logic underrun
);
  // R8
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && txEnable) |=> (sdOut == 1'b0 && sclk == $past(fallLaunch)));

  // R4
  tick_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txEnable && !bitTick) |=> ($stable(sclk) && $stable(sdOut)));

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !clrUnderrun) |=> underrun);

  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrReady && !(enable && txEnable)) |=> !wrReady);
endmodule

bind tdm_audio_tx tdm_audio_tx_chk chk (
  .clk(clk), .rstN(rstN), .enable(enable), .txEnable(txEnable),
  .bitTick(bitTick), .fallLaunch(fallLaunch), .clrUnderrun(clrUnderrun),
  .wrReady(wrReady), .sclk(sclk), .sdOut(sdOut), .underrun(underrun)
);

// File: tb/tdm_audio_tx_test.sv
module tdm_audio_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rstN = 1'b0, bitTick = 1'b0, enable = 1'b0, txEnable = 1'b0;
  logic [3:0] wordCode = 4'h3;
  logic [4:0] slotsM1 = '0;
  logic lsbFirst = 0, fallLaunch = 0, fsInvert = 0, fsOneBit = 0, fsEarly = 0;
  logic [31:0] slotMask = '0;
  logic wrValid = 0, clrUnderrun = 0;
  logic [31:0] wrData = '0;
  logic wrReady, sclk, fsOut, sdOut, underrun;

  int tests = 0, fails = 0;
  logic [31:0] words [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_audio_tx #(.MAX_SLOTS(32), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .enable(enable), .txEnable(txEnable),
    .wordCode(wordCode), .slotsM1(slotsM1), .lsbFirst(lsbFirst), .fallLaunch(fallLaunch),
    .fsInvert(fsInvert), .fsOneBit(fsOneBit), .fsEarly(fsEarly), .slotMask(slotMask),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady), .clrUnderrun(clrUnderrun),
    .sclk(sclk), .fsOut(fsOut), .sdOut(sdOut), .underrun(underrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit selBit(input logic [31:0] w, input int b, input int wb, input bit lsb);
    return lsb ? w[32 - wb + b] : w[31 - b];
  endfunction

  task automatic runCfg(input int id, input logic [3:0] code, input int sm1, input logic [4:0] mode,
                        input logic [2:0] mask);
    int wb, ns, fb, nU, needed, nW, pushIdx, k, target, guard, p, r, s, b, f, wIdx;
    bit lsb, fall, inv, one, early, lastValid, lastReady, prevSclk, urExp, lastSd, lastFs, eSd, eFs, lastF;
    lsb = mode[0]; fall = mode[1]; inv = mode[2]; one = mode[3]; early = mode[4];
    wb = (code >= 4'hb) ? 24 : 2 * (int'(code) + 1);
    ns = sm1 + 1; fb = wb * ns; nU = 0;
    for (int i = 0; i < ns; i++) if (!mask[i]) nU++;
    needed = 3 * nU; nW = needed - 1;
    for (int i = 0; i < 128; i++) words[i] = 32'hA5C3_1E0F ^ (32'(i) * 32'h9E37_79B9) ^ (32'(id) << 8);
    @(negedge clk);
    wordCode = code; slotsM1 = 5'(sm1); lsbFirst = lsb; fallLaunch = fall;
    fsInvert = inv; fsOneBit = one; fsEarly = early; slotMask = {29'b0, mask};
    enable = 0; txEnable = 0;
    lastValid = 0; lastReady = 0; pushIdx = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (lastValid && lastReady) pushIdx++;
      lastValid = (pushIdx < nW); wrValid = lastValid; wrData = words[pushIdx]; lastReady = wrReady;
      bitTick = ~bitTick;
    end
    if (nW >= DEPTH) check("R11 queue full", 32'(wrReady), 32'd0);
    enable = 1; txEnable = 1;
    prevSclk = sclk; urExp = 0; lastSd = 0; lastFs = 0;
    k = 0; target = int'(early) + 3 * fb; guard = 0;
    while (k < target && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (lastValid && lastReady) pushIdx++;
      if (sclk !== prevSclk) begin
        if (prevSclk == fall) begin
          if (early && k == 0) begin
            eSd = 0; eFs = 1;
            check("R7 lead-in data", 32'(sdOut), 32'd0);
          end else begin
            p = k - int'(early); r = p % fb; s = r / wb; b = r % wb; f = p / fb;
            lastF = (r == fb - 1);
            if (early) eFs = one ? lastF : (lastF || (s == 0 && b < wb - 1));
            else       eFs = one ? (r == 0) : (s == 0);
            if (mask[s]) begin
              check("R9 masked slot", 32'(sdOut), 32'd0);
            end else begin
              wIdx = f * nU;
              for (int j = 0; j < s; j++) if (!mask[j]) wIdx++;
              if (wIdx >= nW) begin
                if (b == 0) urExp = 1;
                check("R10 underrun data", 32'(sdOut), 32'd0);
              end else begin
                eSd = selBit(words[wIdx], b, wb, lsb);
                check("R1 R3 R11 data bit", 32'(sdOut), 32'(eSd));
              end
            end
          end
          check("R2 R5 R6 R7 frame sync", 32'(fsOut), 32'(eFs ^ inv));
          check("R10 flag timing", 32'(underrun), 32'(urExp));
          lastSd = sdOut; lastFs = fsOut; k++;
        end else begin
          check("R4 data held on idle edge", {30'b0, sdOut, fsOut}, {30'b0, lastSd, lastFs});
        end
      end
      prevSclk = sclk;
      bitTick = ~bitTick;
      lastValid = (pushIdx < nW); wrValid = lastValid; wrData = words[pushIdx]; lastReady = wrReady;
    end
    check("R4 bit progress", 32'(k), 32'(target));
    enable = 0; txEnable = 0; wrValid = 0;
    @(negedge clk); @(negedge clk);
    check("R8 idle data", 32'(sdOut), 32'd0);
    check("R8 idle sync", 32'(fsOut), 32'(inv));
    check("R8 idle clock", 32'(sclk), 32'(fall));
    check("R11 all words taken", 32'(pushIdx), 32'(nW));
    check("R10 sticky set", 32'(underrun), 32'd1);
    clrUnderrun = 1;
    @(negedge clk);
    clrUnderrun = 0;
    check("R10 cleared", 32'(underrun), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; tests++;
    $display("FAIL R4 watchdog expired actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int id;
    repeat (3) @(negedge clk);
    check("R8 reset data", 32'(sdOut), 32'd0);
    check("R8 reset sync", 32'(fsOut), 32'd0);
    check("R10 reset flag", 32'(underrun), 32'd0);
    check("R11 reset ready", 32'(wrReady), 32'd1);
    rstN = 1;
    // R8: only one of the two enables set
    enable = 1; txEnable = 0;
    for (int c = 0; c < 10; c++) begin @(negedge clk); bitTick = ~bitTick; end
    check("R8 global only clock", 32'(sclk), 32'd0);
    check("R8 global only data", 32'(sdOut), 32'd0);
    enable = 0; txEnable = 1;
    for (int c = 0; c < 10; c++) begin @(negedge clk); bitTick = ~bitTick; end
    check("R8 tx only clock", 32'(sclk), 32'd0);
    check("R8 tx only sync", 32'(fsOut), 32'd0);
    txEnable = 0;
    id = 0;
    for (int ci = 0; ci < 2; ci++)
      for (int si = 0; si < 2; si++)
        for (int m = 0; m < 32; m++) begin
          logic [2:0] mk;
          mk = 3'b000;
          if (si == 1 && m[0]) mk = 3'b010;
          else if (si == 1 && m[1]) mk = 3'b100;
          runCfg(id, (ci == 0) ? 4'h1 : 4'h3, si * 2, 5'(m), mk);
          id++;
        end
    runCfg(id++, 4'hb, 1, 5'b00000, 3'b000);
    runCfg(id++, 4'hb, 1, 5'b11011, 3'b000);
    runCfg(id++, 4'hf, 1, 5'b00101, 3'b000);
    runCfg(id++, 4'hf, 1, 5'b10110, 3'b001);
    runCfg(id++, 4'h9, 0, 5'b00000, 3'b000);
    runCfg(id++, 4'h9, 0, 5'b11111, 3'b000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule